// File: doc/BRIEF.md
# Nibble-Coded 8-bit Stored-Program Processor

This block is a small multicycle processor core with sixteen 8-bit general registers, an 8-bit program counter and a private 256-byte memory that holds both code and data. Every instruction is 16 bits wide and sits in two adjacent bytes. The most significant nibble selects one of twelve operations. The other three nibbles name registers, a rotate count, an address or an immediate byte. Each instruction takes three clock cycles: one to read the high byte, one to read the low byte, and one to execute.

A host fills memory through a valid/ready preload port while the core is not running. A write is accepted on any clock edge where both `pre_valid` and `pre_ready` are high. `pre_ready` drops for as long as the core runs, so a host that holds `pre_valid` waits and does not lose data. A pulse on `start` runs the program from address 00 until the halt word. A combinational debug port reads any register or memory byte at any time. Floating-point add and any undefined operation codes set a sticky flag and otherwise do nothing.

Top module: `nibble_cpu`

## Requirements
- R1: A synchronous reset clears all sixteen registers to 00, sets the program counter to 00, and leaves `busy`, `halted` and `unsupported` low with `pre_ready` high.
- R2: `pre_ready` equals NOT `busy`. A preload write to memory happens exactly on clock edges where `pre_valid` and `pre_ready` are both high. A preload attempted while the core runs leaves memory unchanged.
- R3: A `start` while not busy sets PC to 00 and clears `unsupported`. The core reads the byte at PC as the high instruction byte, then the byte at PC+1 as the low byte, then adds 2 to PC modulo 256. In the instruction word, bits 15:12 are the operation code, 11:8 are field A, 7:4 are field B and 3:0 are field C. Each instruction takes exactly 3 cycles.
- R4: Code 1 loads register A from memory at address {B,C}. Code 2 loads register A with the byte {B,C}. Code 3 writes register A to memory at address {B,C}.
- R5: Code 4 copies register B into register C, and field A has no effect.
- R6: Code 5 writes into register A the sum of registers B and C modulo 256.
- R7: Codes 7, 8 and 9 write into register A the bitwise OR, AND and XOR of registers B and C, respectively.
- R8: Code A rotates register A right C times. On each step bit 0 moves into bit 7. A count of 0 or 8 leaves the register unchanged.
- R9: Code B sets PC to {B,C} when register A equals register 0. Otherwise execution falls through to the next instruction.
- R10: The word C000 stops the core. `halted` rises, `busy` falls, and PC holds the address after the halt word until the next `start` or reset.
- R11: Codes 0, 6, D, E, F, and code C with nonzero operands, change no register or memory byte. They set `unsupported`, which stays set until `start` or reset, and execution continues with the next instruction.
- R12: `dbg_data` shows register `dbg_addr[3:0]` when `dbg_sel` is 0 and memory byte `dbg_addr` when `dbg_sel` is 1, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin execution at address 00 |
| pre_valid | input | 1 | Preload byte offered |
| pre_ready | output | 1 | Preload byte can be accepted (core idle or halted) |
| pre_addr | input | 8 | Preload memory address |
| pre_data | input | 8 | Preload memory byte |
| dbg_sel | input | 1 | Debug source: 0 register, 1 memory |
| dbg_addr | input | 8 | Debug register index (low nibble) or memory address |
| dbg_data | output | 8 | Debug read value |
| busy | output | 1 | Core is fetching or executing |
| halted | output | 1 | Core has stopped on the halt word |
| unsupported | output | 1 | Sticky flag for a no-operation code |
| pc | output | 8 | Program counter |

## Verification
The bench targets rotation counts of zero, eight and above eight. A design that rotated left or dropped the wrap would leave the wrong byte in the register. It tests an addition whose carry is discarded, and a copy with a nonzero ignored nibble that a careless decoder would treat as the source. It runs the program counter past FF into 00, and a jump taken against a moving register 0, where a wrong wrap or wrong compare sends execution to the wrong address or into a loop. It tries a preload during a run, and sends undefined codes mixed with real work. A leaky design would corrupt memory, write a register, or lose the sticky flag. Random programs are compared register by register and byte by byte with a bench interpreter, and the cycle count is checked against three cycles per instruction.

// File: rtl/ncpu_pkg.sv
package ncpu_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 8;
  localparam int NREG   = 16;
  localparam int REG_AW = $clog2(NREG);
  localparam int ROT_W  = $clog2(DATA_W);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH_HI,
    ST_FETCH_LO,
    ST_EXEC,
    ST_HALT
  } state_t;

  typedef enum logic [2:0] {
    ALU_ADD,
    ALU_OR,
    ALU_AND,
    ALU_XOR,
    ALU_ROR
  } alu_op_t;

  localparam logic [3:0] OP_LDM = 4'h1;
  localparam logic [3:0] OP_LDI = 4'h2;
  localparam logic [3:0] OP_STM = 4'h3;
  localparam logic [3:0] OP_MOV = 4'h4;
  localparam logic [3:0] OP_ADD = 4'h5;
  localparam logic [3:0] OP_IOR = 4'h7;
  localparam logic [3:0] OP_AND = 4'h8;
  localparam logic [3:0] OP_XOR = 4'h9;
  localparam logic [3:0] OP_ROR = 4'hA;
  localparam logic [3:0] OP_JEQ = 4'hB;
  localparam logic [3:0] OP_HLT = 4'hC;
endpackage

// File: rtl/ncpu_alu.sv
module ncpu_alu
  import ncpu_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  alu_op_t             op,
  input  logic [W-1:0]        a,
  input  logic [W-1:0]        b,
  input  logic [$clog2(W)-1:0] cnt,
  output logic [W-1:0]        y
);
  localparam int SW = $clog2(W);

  // barrel rotator: stage k rotates right by 2**k when cnt[k] is set
  logic [W-1:0] stage [SW+1];
  assign stage[0] = a;

  generate
    for (genvar k = 0; k < SW; k++) begin : g_ror
      localparam int SH = 1 << k;
      assign stage[k+1] = cnt[k] ? {stage[k][SH-1:0], stage[k][W-1:SH]} : stage[k];
    end
  endgenerate

  always_comb begin
    unique case (op)
      ALU_ADD: y = a + b;
      ALU_OR:  y = a | b;
      ALU_AND: y = a & b;
      ALU_XOR: y = a ^ b;
      default: y = stage[SW];
    endcase
  end
endmodule

// File: rtl/ncpu_regfile.sv
module ncpu_regfile #(
  parameter int W  = 8,
  parameter int N  = 16,
  parameter int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] ra_addr,
  output logic [W-1:0]  ra_data,
  input  logic [AW-1:0] rb_addr,
  output logic [W-1:0]  rb_data,
  output logic [W-1:0]  r0_data,
  input  logic [AW-1:0] dbg_addr,
  output logic [W-1:0]  dbg_data
);
  logic [W-1:0] regs [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) regs[i] <= '0;
    end else if (we) begin
      regs[waddr] <= wdata;
    end
  end

  assign ra_data  = regs[ra_addr];
  assign rb_data  = regs[rb_addr];
  assign r0_data  = regs[0];
  assign dbg_data = regs[dbg_addr];
endmodule

// File: rtl/ncpu_mem.sv
module ncpu_mem #(
  parameter int W  = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata,
  input  logic [AW-1:0] dbg_addr,
  output logic [W-1:0]  dbg_data
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata    = cells[raddr];
  assign dbg_data = cells[dbg_addr];
endmodule

// File: rtl/nibble_cpu.sv
module nibble_cpu
  import ncpu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              pre_valid,
  output logic              pre_ready,
  input  logic [ADDR_W-1:0] pre_addr,
  input  logic [DATA_W-1:0] pre_data,
  input  logic              dbg_sel,
  input  logic [ADDR_W-1:0] dbg_addr,
  output logic [DATA_W-1:0] dbg_data,
  output logic              busy,
  output logic              halted,
  output logic              unsupported,
  output logic [ADDR_W-1:0] pc
);
  state_t            state;
  logic [ADDR_W-1:0] pc_q;
  logic [DATA_W-1:0] ir_hi, ir_lo;
  logic              unsup_q;

  // instruction fields
  logic [3:0] f_op, f_a, f_b, f_c;
  assign f_op = ir_hi[7:4];
  assign f_a  = ir_hi[3:0];
  assign f_b  = ir_lo[7:4];
  assign f_c  = ir_lo[3:0];

  // register file wiring
  logic              rf_we;
  logic [REG_AW-1:0] rf_waddr, ra_addr, rb_addr;
  logic [DATA_W-1:0] rf_wdata, ra_data, rb_data, r0_data, rf_dbg;

  // memory wiring
  logic              mem_we, mem_st;
  logic [ADDR_W-1:0] mem_waddr, mem_raddr;
  logic [DATA_W-1:0] mem_wdata, mem_rdata, mem_dbg;

  // alu wiring
  alu_op_t           alu_op;
  logic [DATA_W-1:0] alu_y;

  logic take_jump, do_halt, bad_op, src_from_b;

  assign busy        = (state == ST_FETCH_HI) || (state == ST_FETCH_LO) || (state == ST_EXEC);
  assign halted      = (state == ST_HALT);
  assign pre_ready   = !busy;
  assign unsupported = unsup_q;
  assign pc          = pc_q;

  // operand sources: register-register forms read fields B and C
  assign src_from_b = (f_op == OP_MOV) || (f_op == OP_ADD) || (f_op == OP_IOR) ||
                      (f_op == OP_AND) || (f_op == OP_XOR);
  assign ra_addr    = src_from_b ? f_b : f_a;
  assign rb_addr    = f_c;

  always_comb begin
    unique case (state)
      ST_FETCH_HI: mem_raddr = pc_q;
      ST_FETCH_LO: mem_raddr = pc_q + ADDR_W'(1);
      default:     mem_raddr = ir_lo;
    endcase
  end

  always_comb begin
    unique case (f_op)
      OP_IOR:  alu_op = ALU_OR;
      OP_AND:  alu_op = ALU_AND;
      OP_XOR:  alu_op = ALU_XOR;
      OP_ROR:  alu_op = ALU_ROR;
      default: alu_op = ALU_ADD;
    endcase
  end

  // execute-stage decode
  always_comb begin
    rf_we     = 1'b0;
    rf_waddr  = f_a;
    rf_wdata  = alu_y;
    mem_st    = 1'b0;
    take_jump = 1'b0;
    do_halt   = 1'b0;
    bad_op    = 1'b0;
    if (state == ST_EXEC) begin
      unique case (f_op)
        OP_LDM: begin rf_we = 1'b1; rf_wdata = mem_rdata; end
        OP_LDI: begin rf_we = 1'b1; rf_wdata = ir_lo; end
        OP_STM: mem_st = 1'b1;
        OP_MOV: begin rf_we = 1'b1; rf_waddr = f_c; rf_wdata = ra_data; end
        OP_ADD, OP_IOR, OP_AND, OP_XOR, OP_ROR: rf_we = 1'b1;
        OP_JEQ: take_jump = (ra_data == r0_data);
        OP_HLT: begin
          if (f_a == 4'h0 && ir_lo == 8'h00) do_halt = 1'b1;
          else                               bad_op  = 1'b1;
        end
        default: bad_op = 1'b1;
      endcase
    end
  end

  assign mem_we    = (pre_valid && pre_ready) || mem_st;
  assign mem_waddr = mem_st ? ir_lo   : pre_addr;
  assign mem_wdata = mem_st ? ra_data : pre_data;

  assign dbg_data  = dbg_sel ? mem_dbg : rf_dbg;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      pc_q    <= '0;
      ir_hi   <= '0;
      ir_lo   <= '0;
      unsup_q <= 1'b0;
    end else begin
      unique case (state)
        ST_FETCH_HI: begin
          ir_hi <= mem_rdata;
          state <= ST_FETCH_LO;
        end
        ST_FETCH_LO: begin
          ir_lo <= mem_rdata;
          pc_q  <= pc_q + ADDR_W'(2);
          state <= ST_EXEC;
        end
        ST_EXEC: begin
          state <= do_halt ? ST_HALT : ST_FETCH_HI;
          if (take_jump) pc_q <= ir_lo;
          if (bad_op)    unsup_q <= 1'b1;
        end
        default: begin
          if (start) begin
            state   <= ST_FETCH_HI;
            pc_q    <= '0;
            unsup_q <= 1'b0;
          end
        end
      endcase
    end
  end

  ncpu_regfile #(.W(DATA_W), .N(NREG), .AW(REG_AW)) u_rf (
    .clk      (clk),
    .rst      (rst),
    .we       (rf_we),
    .waddr    (rf_waddr),
    .wdata    (rf_wdata),
    .ra_addr  (ra_addr),
    .ra_data  (ra_data),
    .rb_addr  (rb_addr),
    .rb_data  (rb_data),
    .r0_data  (r0_data),
    .dbg_addr (dbg_addr[REG_AW-1:0]),
    .dbg_data (rf_dbg)
  );

  ncpu_mem #(.W(DATA_W), .AW(ADDR_W)) u_mem (
    .clk      (clk),
    .we       (mem_we),
    .waddr    (mem_waddr),
    .wdata    (mem_wdata),
    .raddr    (mem_raddr),
    .rdata    (mem_rdata),
    .dbg_addr (dbg_addr),
    .dbg_data (mem_dbg)
  );

  ncpu_alu #(.W(DATA_W)) u_alu (
    .op  (alu_op),
    .a   (ra_data),
    .b   (rb_data),
    .cnt (f_c[ROT_W-1:0]),
    .y   (alu_y)
  );
endmodule

// File: rtl/ncpu_checker.sv
module ncpu_checker (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       pre_ready,
  input logic       busy,
  input logic       halted,
  input logic       unsupported,
  input logic [7:0] pc
);
  // R1: reset leaves the core idle at address 00
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!busy && !halted && !unsupported && pc == 8'h00));

  // R2: no preload can be accepted while running
  a_r2_no_accept_busy: assert property (@(posedge clk) disable iff (rst)
    busy |-> !pre_ready);

  // R3: start from rest enters fetch at address 00
  a_r3_start_at_zero: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> (busy && pc == 8'h00));

  // R10: a halted core is never busy
  a_r10_halt_not_busy: assert property (@(posedge clk) disable iff (rst)
    halted |-> !busy);

  // R10: halt holds its state and PC until start
  a_r10_halt_holds: assert property (@(posedge clk) disable iff (rst)
    (halted && !start) |=> (halted && $stable(pc)));

  // R11: the flag is sticky until start
  a_r11_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (unsupported && !start) |=> unsupported);
endmodule

bind nibble_cpu ncpu_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .start       (start),
  .pre_ready   (pre_ready),
  .busy        (busy),
  .halted      (halted),
  .unsupported (unsupported),
  .pc          (pc)
);

// File: tb/tb_nibble_cpu.sv
`timescale 1ns/1ps
module tb_nibble_cpu;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       pre_valid = 1'b0;
  logic       pre_ready;
  logic [7:0] pre_addr = '0;
  logic [7:0] pre_data = '0;
  logic       dbg_sel = 1'b0;
  logic [7:0] dbg_addr = '0;
  logic [7:0] dbg_data;
  logic       busy, halted, unsupported;
  logic [7:0] pc;

  int n_chk = 0;
  int n_err = 0;

  // bench model state
  logic [7:0] m_reg [16];
  logic [7:0] m_mem [256];
  logic [7:0] m_pc;
  logic       m_unsup;
  int         m_steps;

  always #4 clk = ~clk;

  nibble_cpu dut (
    .clk (clk), .rst (rst), .start (start),
    .pre_valid (pre_valid), .pre_ready (pre_ready),
    .pre_addr (pre_addr), .pre_data (pre_data),
    .dbg_sel (dbg_sel), .dbg_addr (dbg_addr), .dbg_data (dbg_data),
    .busy (busy), .halted (halted), .unsupported (unsupported), .pc (pc)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] ror_ref(logic [7:0] v, logic [3:0] n);
    for (int i = 0; i < int'(n); i++) v = {v[0], v[7:1]};
    return v;
  endfunction

  // interpreter written from the requirements
  task automatic model_run();
    logic [7:0] hi, lo;
    logic [3:0] op, fa, fb, fc;
    bit stop = 0;
    m_pc = 8'h00; m_unsup = 1'b0; m_steps = 0;
    while (!stop && m_steps < 1000) begin
      hi = m_mem[m_pc]; lo = m_mem[m_pc + 8'd1]; m_pc = m_pc + 8'd2;
      op = hi[7:4]; fa = hi[3:0]; fb = lo[7:4]; fc = lo[3:0];
      m_steps++;
      case (op)
        4'h1: m_reg[fa] = m_mem[lo];
        4'h2: m_reg[fa] = lo;
        4'h3: m_mem[lo] = m_reg[fa];
        4'h4: m_reg[fc] = m_reg[fb];
        4'h5: m_reg[fa] = m_reg[fb] + m_reg[fc];
        4'h7: m_reg[fa] = m_reg[fb] | m_reg[fc];
        4'h8: m_reg[fa] = m_reg[fb] & m_reg[fc];
        4'h9: m_reg[fa] = m_reg[fb] ^ m_reg[fc];
        4'hA: m_reg[fa] = ror_ref(m_reg[fa], fc);
        4'hB: if (m_reg[fa] == m_reg[0]) m_pc = lo;
        4'hC: if (fa == 4'h0 && lo == 8'h00) stop = 1; else m_unsup = 1'b1;
        default: m_unsup = 1'b1;
      endcase
    end
  endtask

  task automatic put16(int addr, logic [15:0] w);
    m_mem[addr[7:0]]        = w[15:8];
    m_mem[addr[7:0] + 8'd1] = w[7:0];
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) m_mem[i] = 8'($urandom);
  endtask

  task automatic preload_all();
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      pre_valid = 1'b1; pre_addr = 8'(i); pre_data = m_mem[i];
    end
    @(negedge clk);
    pre_valid = 1'b0;
  endtask

  // start, optionally try a preload mid-run, wait for halt
  task automatic run_dut(string req, bit poke);
    int cnt = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!halted && cnt < 5000) begin
      if (poke && cnt == 2) begin
        pre_valid = 1'b1; pre_addr = 8'h90; pre_data = ~m_mem[8'h90];
        #1 chk("R2", "pre_ready while busy", pre_ready, 1'b0);
      end
      @(negedge clk);
      pre_valid = 1'b0;
      cnt++;
    end
    chk(req, "reached halt", halted, 1'b1);
    chk("R3", "cycles per run", cnt, 3 * m_steps);
  endtask

  task automatic compare_all(string req);
    int bad = 0;
    logic [7:0] first = '0;
    dbg_sel = 1'b0;
    for (int r = 0; r < 16; r++) begin
      dbg_addr = 8'(r); #1;
      chk(req, $sformatf("reg %0d", r), dbg_data, m_reg[r]);
    end
    dbg_sel = 1'b1;
    for (int a = 0; a < 256; a++) begin
      dbg_addr = 8'(a); #1;
      if (dbg_data !== m_mem[a]) begin
        if (bad == 0) first = 8'(a);
        bad++;
      end
    end
    chk(req, $sformatf("memory mismatches (first at %0h)", first), bad, 0);
    chk("R10", "pc after halt", pc, m_pc);
    chk("R10", "busy low after halt", busy, 1'b0);
    chk("R11", "unsupported flag", unsupported, m_unsup);
  endtask

  task automatic read_reg(int r, output logic [7:0] v);
    dbg_sel = 1'b0; dbg_addr = 8'(r); #1; v = dbg_data;
  endtask

  task automatic gen_random(int n);
    logic [3:0] op, fa;
    logic [7:0] lo;
    clear_mem();
    for (int k = 0; k < n; k++) begin
      op = 4'($urandom % 16);
      fa = 4'($urandom);
      lo = 8'($urandom);
      if (op == 4'hB) op = 4'h5;
      if (op == 4'h3) lo = lo | 8'h80;
      if (op == 4'hC) fa = 4'(($urandom % 15) + 1);
      put16(2 * k, {op, fa, lo});
    end
    put16(2 * n, 16'hC000);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0] v, pc_hold;
    void'($urandom(32'h1DE5_0C0A));
    for (int r = 0; r < 16; r++) m_reg[r] = 8'h00;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state, read through R12 debug port
    chk("R1", "busy", busy, 1'b0);
    chk("R1", "halted", halted, 1'b0);
    chk("R1", "pc", pc, 8'h00);
    chk("R1", "unsupported", unsupported, 1'b0);
    chk("R1", "pre_ready", pre_ready, 1'b1);
    for (int r = 0; r < 16; r++) begin
      read_reg(r, v);
      chk("R1", $sformatf("R12 debug reg %0d", r), v, 8'h00);
    end

    // example program: counting loop with both jump outcomes (R9)
    clear_mem();
    put16(8'h00, 16'h2006); put16(8'h02, 16'h2101); put16(8'h04, 16'h4012);
    put16(8'h06, 16'h5112); put16(8'h08, 16'hB10C); put16(8'h0A, 16'hB006);
    put16(8'h0C, 16'hC000);
    preload_all();
    model_run();
    run_dut("R9", 1'b0);
    compare_all("R9");
    read_reg(0, v); chk("R9", "example r0", v, 8'h06);
    read_reg(1, v); chk("R9", "example r1", v, 8'h06);
    chk("R10", "example pc", pc, 8'h0E);
    pc_hold = pc;
    repeat (5) @(negedge clk);
    chk("R10", "halt persists", halted, 1'b1);
    chk("R10", "pc steady in halt", pc, pc_hold);

    // loads, store, add with carry, copy with ignored nibble, logic ops
    clear_mem();
    m_mem[8'hF0] = 8'h3C;
    put16(8'h00, 16'h11F0); put16(8'h02, 16'h22C8); put16(8'h04, 16'h5312);
    put16(8'h06, 16'h33E0); put16(8'h08, 16'h4016); put16(8'h0A, 16'h4F27);
    put16(8'h0C, 16'h7812); put16(8'h0E, 16'h8912); put16(8'h10, 16'h9A12);
    put16(8'h12, 16'hC000);
    preload_all();
    model_run();
    run_dut("R4", 1'b0);
    compare_all("R4");
    read_reg(3, v);  chk("R6", "sum carry dropped", v, 8'h04);
    read_reg(6, v);  chk("R5", "copy r1 to r6", v, 8'h3C);
    read_reg(7, v);  chk("R5", "copy ignores field A", v, 8'hC8);
    read_reg(8, v);  chk("R7", "or", v, 8'hFC);
    read_reg(9, v);  chk("R7", "and", v, 8'h08);
    read_reg(10, v); chk("R7", "xor", v, 8'hF4);
    dbg_sel = 1'b1; dbg_addr = 8'hE0; #1;
    chk("R4", "stored byte", dbg_data, 8'h04);

    // rotation counts 3, 0, 8 and 11 (R8)
    clear_mem();
    put16(8'h00, 16'h22B5); put16(8'h02, 16'hA203);
    put16(8'h04, 16'h23B5); put16(8'h06, 16'hA300);
    put16(8'h08, 16'h24B5); put16(8'h0A, 16'hA408);
    put16(8'h0C, 16'h25B5); put16(8'h0E, 16'hA50B);
    put16(8'h10, 16'hC000);
    preload_all();
    model_run();
    run_dut("R8", 1'b0);
    compare_all("R8");
    read_reg(2, v); chk("R8", "ror 3", v, 8'hB6);
    read_reg(3, v); chk("R8", "ror 0", v, 8'hB5);
    read_reg(4, v); chk("R8", "ror 8", v, 8'hB5);
    read_reg(5, v); chk("R8", "ror 11", v, 8'hB6);

    // no-operation codes (R11)
    clear_mem();
    put16(8'h00, 16'h2155); put16(8'h02, 16'h6123); put16(8'h04, 16'h0FFF);
    put16(8'h06, 16'hD000); put16(8'h08, 16'hC100); put16(8'h0A, 16'hE1AA);
    put16(8'h0C, 16'hF1AA); put16(8'h0E, 16'h2266); put16(8'h10, 16'hC000);
    preload_all();
    model_run();
    run_dut("R11", 1'b0);
    compare_all("R11");
    chk("R11", "flag set", unsupported, 1'b1);
    read_reg(1, v); chk("R11", "r1 untouched", v, 8'h55);
    read_reg(2, v); chk("R11", "ran past no-ops", v, 8'h66);

    // start clears the flag (R11): rerun a clean program
    clear_mem();
    put16(8'h00, 16'h2001); put16(8'h02, 16'h2402); put16(8'h04, 16'hC000);
    preload_all();
    model_run();
    run_dut("R11", 1'b0);
    compare_all("R11");
    chk("R11", "flag cleared by start", unsupported, 1'b0);

    // PC wraps from FF to 00 (R3)
    clear_mem();
    put16(8'h00, 16'hB40A); put16(8'h02, 16'h2000); put16(8'h04, 16'h2400);
    put16(8'h06, 16'hB0FE); put16(8'h0A, 16'hC000); put16(8'hFE, 16'h2577);
    preload_all();
    model_run();
    run_dut("R3", 1'b0);
    compare_all("R3");
    read_reg(5, v); chk("R3", "instruction at FE ran", v, 8'h77);
    chk("R3", "pc after wrap", pc, 8'h0C);

    // random straight-line programs, first with a preload attempt while busy (R2)
    for (int t = 0; t < 12; t++) begin
      gen_random(20 + int'($urandom % 40));
      preload_all();
      model_run();
      run_dut("R7", t == 0);
      compare_all(t == 0 ? "R2" : "R7");
    end

    // reset mid-run returns to rest (R1)
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0; rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1", "busy after reset", busy, 1'b0);
    chk("R1", "pc after reset", pc, 8'h00);
    read_reg(1, v); chk("R1", "reg cleared", v, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule